// File: doc/BRIEF.md
# Lock-Protected Debug Cycle Counter

A memory-mapped peripheral that counts clock cycles for software profiling. It sits on a simple 32-bit register bus: an address, a write strobe, write data, and read data that is valid in the same cycle. Software unlocks the unit with a 32-bit key, sets the enable bit in the control register, and then reads the free-running 32-bit count. Writing any other value to the key register locks the unit again.

A lock blocks writes to the control register, so stray stores cannot start or stop the counter. The lock state is visible in a status register. An external trace-enable input gates the whole unit. While it is low, every register reads as zero, writes are dropped and the count is frozen.

Top module: `dbg_cycle_counter`

## Requirements
- R1: After reset the unit is locked (status reads 0x3), the control register reads 0x40000000 and the count reads 0.
- R2: A write of 0xC5ACCE55 to the key register (offset 0xFB0) unlocks the unit, and any other written value locks it. The status register (offset 0xFB4) reads 0x1 when unlocked and 0x3 when locked: bit 0 is always 1 and bit 1 is the lock flag. Writes to the status register change nothing.
- R3: While the unit is locked, a write to the control register (offset 0x000) does not change it.
- R4: Only bit 0 of the control register can be written, and it is the enable bit. The register reads 0x40000000 OR the enable bit, whatever else is written.
- R5: While enable is 1 and trace-enable is high, the count (offset 0x004) rises by exactly one per clock.
- R6: The count register takes the written value whether the unit is locked or unlocked.
- R7: A count write in a cycle where an increment would also happen loads the written value, with no increment added.
- R8: The count wraps from 0xFFFFFFFF to 0 with no other effect.
- R9: The key register reads 0, and any address other than the four defined offsets reads 0.
- R10: While trace-enable is low, every address reads 0, the count holds its value and all writes are ignored. When trace-enable returns high, the held count reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trace_en_i | input | 1 | Global trace enable; gates reads, writes and counting |
| addr_i | input | 12 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |

## Verification
The embedded assertions check these on every clock:
- the count steps by exactly one when it runs;
- a write wins over an increment;
- the count freezes when it is not running;
- the control enable holds while the unit is locked;
- the key write has the right effect on the lock;
- reads are zero while trace-enable is low.

Only the bench scenarios show the following, because they depend on what software sees:
- the register readback values;
- the fixed capability bits;
- the wrap from all ones to zero;
- the count value held across a trace-enable low period;
- that the lock leaves count writes untouched.

// File: rtl/dbg_ccnt_pkg.sv
package dbg_ccnt_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_KEY    = 12'hFB0;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'hFB4;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;
  localparam logic [DATA_W-1:0] CTRL_CAP   = 32'h4000_0000;

  typedef struct packed {
    logic ctrl;
    logic count;
    logic key;
    logic status;
  } reg_sel_t;
endpackage

// File: rtl/dbg_ccnt_lock.sv
module dbg_ccnt_lock
  import dbg_ccnt_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter logic [DW-1:0] KEY = UNLOCK_KEY
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          locked_o,
  output logic [DW-1:0] status_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       locked_q <= 1'b1;
    else if (key_wr_i) locked_q <= (wdata_i != KEY);
  end

  assign locked_o = locked_q;
  // bit0: lock present, bit1: locked
  assign status_o = {{(DW-2){1'b0}}, locked_q, 1'b1};

  assert_key_unlocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && wdata_i == KEY) |=> !locked_o);
  assert_other_locks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && wdata_i != KEY) |=> locked_o);
  assert_lock_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_wr_i |=> $stable(locked_o));
endmodule

// File: rtl/dbg_ccnt_ctrl.sv
module dbg_ccnt_ctrl
  import dbg_ccnt_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter logic [DW-1:0] CAP = CTRL_CAP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_wr_i,
  input  logic          en_wdata_i,
  input  logic          locked_i,
  output logic          en_o,
  output logic [DW-1:0] ctrl_rd_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      en_q <= 1'b0;
    else if (ctrl_wr_i && !locked_i)  en_q <= en_wdata_i;
  end

  assign en_o      = en_q;
  assign ctrl_rd_o = CAP | {{(DW-1){1'b0}}, en_q};

  assert_locked_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> $stable(en_o));
  assert_unlocked_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !locked_i) |=> (en_o == $past(en_wdata_i)));
endmodule

// File: rtl/dbg_ccnt_counter.sv
module dbg_ccnt_counter
  import dbg_ccnt_pkg::*;
#(
  parameter int unsigned CW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  // write has priority over increment; wrap is natural
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_wr_i) cnt_q <= wdata_i;
    else if (run_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cnt_wr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
  assert_write_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_o == $past(wdata_i)));
  assert_halt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/dbg_cycle_counter.sv
module dbg_cycle_counter
  import dbg_ccnt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trace_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  reg_sel_t      sel;
  logic          wr_ok;
  logic          locked;
  logic          en;
  logic [DW-1:0] status_rd;
  logic [DW-1:0] ctrl_rd;
  logic [DW-1:0] cnt;

  assign sel.ctrl   = (addr_i == AW'(OFS_CTRL));
  assign sel.count  = (addr_i == AW'(OFS_COUNT));
  assign sel.key    = (addr_i == AW'(OFS_KEY));
  assign sel.status = (addr_i == AW'(OFS_STATUS));
  assign wr_ok      = wr_en_i && trace_en_i;

  dbg_ccnt_lock #(.DW(DW), .KEY(DW'(UNLOCK_KEY))) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (wr_ok && sel.key),
    .wdata_i  (wdata_i),
    .locked_o (locked),
    .status_o (status_rd)
  );

  dbg_ccnt_ctrl #(.DW(DW), .CAP(DW'(CTRL_CAP))) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (wr_ok && sel.ctrl),
    .en_wdata_i (wdata_i[0]),
    .locked_i   (locked),
    .en_o       (en),
    .ctrl_rd_o  (ctrl_rd)
  );

  dbg_ccnt_counter #(.CW(DW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en && trace_en_i),
    .cnt_wr_i (wr_ok && sel.count),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt)
  );

  // key register is write-only; unmapped reads zero
  always_comb begin
    rdata_o = '0;
    if (trace_en_i) begin
      unique case (1'b1)
        sel.ctrl:   rdata_o = ctrl_rd;
        sel.count:  rdata_o = cnt;
        sel.status: rdata_o = status_rd;
        default:    rdata_o = '0;
      endcase
    end
  end

  assert_gate_reads_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trace_en_i |-> (rdata_o == '0));
  assert_key_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel.key |-> (rdata_o == '0));
  assert_status_present_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trace_en_i && sel.status) |-> rdata_o[0]);
endmodule

// File: tb/dbg_cycle_counter_tb.sv
`timescale 1ns/1ps
module dbg_cycle_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_en = 1'b1;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] KEY = 32'hC5AC_CE55;
  localparam int NV = 11;
  // {wr, waddr, wdata, raddr, expected, req}; counting disabled throughout
  localparam logic [92:0] VEC [NV] = '{
    {1'b1, 12'hFB0, 32'h0000_0000, 12'hFB4, 32'h0000_0003, 4'd2},  // R2 relock
    {1'b1, 12'h000, 32'h0000_0001, 12'h000, 32'h4000_0000, 4'd3},  // R3 locked ctrl write
    {1'b1, 12'hFB0, KEY,           12'hFB4, 32'h0000_0001, 4'd2},  // R2 unlock
    {1'b1, 12'hFB0, 32'h1234_5678, 12'hFB4, 32'h0000_0003, 4'd2},  // R2 wrong key
    {1'b1, 12'hFB0, KEY,           12'hFB4, 32'h0000_0001, 4'd2},  // R2
    {1'b1, 12'h000, 32'hFFFF_FFFE, 12'h000, 32'h4000_0000, 4'd4},  // R4 ro bits
    {1'b1, 12'h004, 32'hDEAD_0000, 12'h004, 32'hDEAD_0000, 4'd6},  // R6 unlocked
    {1'b1, 12'hFB0, 32'h0000_0000, 12'hFB0, 32'h0000_0000, 4'd9},  // R9 key reads 0
    {1'b1, 12'h004, 32'h0000_0123, 12'h004, 32'h0000_0123, 4'd6},  // R6 locked
    {1'b0, 12'h000, 32'h0000_0000, 12'h008, 32'h0000_0000, 4'd9},  // R9 unmapped
    {1'b1, 12'hFB4, 32'h0000_0000, 12'hFB4, 32'h0000_0003, 4'd2}   // R2 status ro
  };

  dbg_cycle_counter u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .trace_en_i (trace_en),
    .addr_i     (addr),
    .wr_en_i    (wr),
    .wdata_i    (wdata),
    .rdata_o    (rdata)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(12'hFB4, r); check("R1 status", r, 32'h3);
    bus_read(12'h000, r); check("R1 ctrl", r, 32'h4000_0000);
    bus_read(12'h004, r); check("R1 count", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][92]) bus_write(VEC[i][91:80], VEC[i][79:48]);
      bus_read(VEC[i][47:36], r);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), r, VEC[i][35:4]);
    end

    // R4 enable reads back
    bus_write(12'hFB0, KEY);
    bus_write(12'h000, 32'h1);
    bus_read(12'h000, r); check("R4 ctrl enabled", r, 32'h4000_0001);

    // R7 write wins over increment, R5 one per clock
    bus_write(12'h004, 32'h0);
    bus_read(12'h004, r); check("R7 write priority", r, 32'h0);
    repeat (10) @(negedge clk);
    bus_read(12'h004, r); check("R5 ten cycles", r, 32'd10);

    // R8 wrap
    bus_write(12'h004, 32'hFFFF_FFFE);
    bus_read(12'h004, r); check("R8 preload", r, 32'hFFFF_FFFE);
    @(negedge clk);
    bus_read(12'h004, r); check("R8 all ones", r, 32'hFFFF_FFFF);
    @(negedge clk);
    bus_read(12'h004, r); check("R8 wrap to zero", r, 32'h0);

    // R10 gating: reads zero, count frozen, writes dropped
    bus_read(12'h004, held);
    trace_en = 1'b0;
    bus_read(12'h000, r); check("R10 ctrl gated", r, 32'h0);
    bus_read(12'hFB4, r); check("R10 status gated", r, 32'h0);
    bus_write(12'h004, 32'h55);
    bus_write(12'hFB0, 32'h0);
    repeat (4) @(negedge clk);
    trace_en = 1'b1;
    bus_read(12'h004, r); check("R10 count held", r, held);
    bus_read(12'hFB4, r); check("R10 lock write dropped", r, 32'h1);

    // R3 locked: disable attempt has no effect, counting continues
    bus_write(12'hFB0, 32'h0);
    bus_write(12'h000, 32'h0);
    bus_read(12'h000, r); check("R3 ctrl kept", r, 32'h4000_0001);
    bus_read(12'h004, held);
    repeat (5) @(negedge clk);
    bus_read(12'h004, r); check("R3 still counting", r, held + 32'd5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule